// File: doc/BRIEF.md
# Soft Reset and Non-Maskable Interrupt Entry Controller

This block sits next to a simple in-order CPU pipeline. It turns two kinds of urgent event into one entry to the reset exception vector. The first is a soft-reset request, which can arrive on any cycle. The second is a non-maskable interrupt (NMI), which can be raised by an external pin or by a write to the interrupt register. Both requests arrive asynchronously, so each passes through a two-flop synchronizer. The NMI pin and the soft-reset request are then edge-detected, so that one assertion gives exactly one exception.

A soft reset is taken as soon as its synchronized edge is seen. This happens whether or not the core is executing, and it pulses an abort so that multicycle state machines return to idle. An NMI is held pending. It is taken only while the core runs instructions and only at an instruction boundary, and it never aborts anything.

Both causes write the same architectural result, so software cannot tell them apart:
- In the status register, the soft-reset flag, the error level and the bootstrap-vector select are set, and the TLB-shutdown flag is cleared.
- The cache-error EW flag is cleared.
- The error return PC receives the restart address supplied by the pipeline.
- The PC load value becomes 0xFFFF_FFFF_BFC0_0000, and a one-cycle flush pulse is issued.

Every other status bit keeps its value.

Top module: `nmi_srst_ctrl`

## Requirements
- R1: In the cycle after a synchronous reset, `status` = 0x06 (ERL and BEV set), `cerr_ew` = 0, `err_pc` = 0, `pc_target` = 0, and both `pc_load` and `mc_abort` are low.
- R2: A soft-reset request is taken regardless of `core_running` and `insn_boundary`. `pc_load` goes high after the third rising edge, counting the first edge that samples the request high. It stays high for one cycle.
- R3: On entry, the status bits change as follows: bit 0 (SR) = 1, bit 1 (ERL) = 1, bit 2 (BEV) = 1, bit 3 (TS) = 0. Status bits 7..4 keep their values. `cerr_ew` = 0, `err_pc` = the `next_pc` sampled on the entry edge, and `pc_target` = 0xFFFF_FFFF_BFC0_0000.
- R4: Entries caused by a soft reset and by an NMI, made from the same starting state, leave identical `status`, `cerr_ew`, `err_pc` and `pc_target`.
- R5: An NMI is taken only on an edge where `core_running` and `insn_boundary` are both high. Until then it stays pending.
- R6: `mc_abort` pulses for one cycle together with `pc_load` on a soft-reset entry. It stays low on an NMI entry.
- R7: A soft-reset or NMI input held high gives exactly one entry. An NMI pin edge with the core at a boundary gives `pc_load` after the fourth rising edge, counting the first edge that samples the pin high.
- R8: A write to the interrupt register raises an NMI only if data bit 6 is 1. Other bits have no effect. The pending NMI clears once it is taken, so it gives exactly one entry. That entry comes one edge after the write edge when the core is at a boundary.
- R9: When a soft reset is taken while an NMI is pending, the soft reset wins and the pending NMI is dropped.
- R10: An NMI is taken even when status ERL is already 1.
- R11: `st_wr_en` loads `st_wr_data` into `status`, and `ew_set` sets `cerr_ew`. Both take effect on the next edge, except on an entry edge, where the entry values win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| srst_req_a | input | 1 | Asynchronous soft-reset request |
| nmi_pin_a | input | 1 | Asynchronous NMI pin, active high |
| ireg_wr_en | input | 1 | Interrupt register write strobe |
| ireg_wr_data | input | 8 | Interrupt register write data; bit 6 raises an NMI |
| core_running | input | 1 | Core is executing instructions |
| insn_boundary | input | 1 | Pipeline is at an instruction boundary this cycle |
| next_pc | input | 64 | Restart address: next uncompleted or aborted instruction |
| st_wr_en | input | 1 | Status register write strobe |
| st_wr_data | input | 8 | Status register write data |
| ew_set | input | 1 | Sets the cache-error EW flag |
| status | output | 8 | Status register |
| cerr_ew | output | 1 | Cache-error EW flag |
| err_pc | output | 64 | Error return PC |
| pc_target | output | 64 | PC load value |
| pc_load | output | 1 | One-cycle pipeline flush and PC load pulse |
| mc_abort | output | 1 | One-cycle abort of in-flight multicycle operations |

## Verification
The bench targets the following corner cases:
- **NMI held off the boundary.** A design that ignores the boundary qualifier would enter early.
- **Input held high.** A level-sensitive design would re-enter on every cycle the input stays high.
- **Write with all bits except bit 6.** A design that decodes the wrong bit would take a spurious NMI.
- **Pending NMI under a soft reset.** A design that does not drop the pending NMI would enter a second time after the soft reset.
- **NMI taken with ERL already set.** A design that masks on ERL would refuse this NMI.
- **Preserved status bits.** Full-register overwrites would show up as lost upper status bits.
- **Abort on NMI.** A design that aborts on an NMI would show `mc_abort` on NMI entries.

// File: rtl/nmi_srst_pkg.sv
package nmi_srst_pkg;
  localparam int ST_SR  = 0;
  localparam int ST_ERL = 1;
  localparam int ST_BEV = 2;
  localparam int ST_TS  = 3;
  localparam int IREG_NMI_BIT = 6;
  localparam logic [63:0] RESET_VECTOR = 64'hFFFF_FFFF_BFC0_0000;
endpackage

// File: rtl/nmi_srst_sync.sv
module nmi_srst_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a,
  output logic [W-1:0] rise
);
  logic [W-1:0] s1, s2, s3;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) begin
          s1[g] <= 1'b0;
          s2[g] <= 1'b0;
          s3[g] <= 1'b0;
        end else begin
          s1[g] <= a[g];
          s2[g] <= s1[g];
          s3[g] <= s2[g];
        end
      end
      assign rise[g] = s2[g] & ~s3[g];

      // R7: a held level yields a single edge indication
      a_r7_single_rise: assert property (@(posedge clk) disable iff (rst)
        rise[g] |=> !rise[g]);
    end
  endgenerate
endmodule

// File: rtl/nmi_pend_latch.sv
module nmi_pend_latch #(
  parameter int IRW = 8,
  parameter int BIT = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pin_rise,
  input  logic           wr_en,
  input  logic [IRW-1:0] wr_data,
  input  logic           clr,
  output logic           pend
);
  logic set_req;
  logic unused_wr_bits;

  assign set_req        = pin_rise | (wr_en & wr_data[BIT]);
  assign unused_wr_bits = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst)          pend <= 1'b0;
    else if (clr)     pend <= 1'b0;
    else if (set_req) pend <= 1'b1;
  end

  // R8: a write lacking the NMI bit never raises a pending NMI by itself
  a_r8_wr_decode: assert property (@(posedge clk) disable iff (rst)
    (!pend && wr_en && !wr_data[BIT] && !pin_rise) |=> !pend);
endmodule

// File: rtl/nmi_arch_state.sv
module nmi_arch_state
  import nmi_srst_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int STW  = 8,
  parameter logic [XLEN-1:0] VEC = XLEN'(RESET_VECTOR)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take_srst,
  input  logic            take_nmi,
  input  logic [XLEN-1:0] next_pc,
  input  logic            st_wr_en,
  input  logic [STW-1:0]  st_wr_data,
  input  logic            ew_set,
  output logic [STW-1:0]  status,
  output logic            cerr_ew,
  output logic [XLEN-1:0] err_pc,
  output logic [XLEN-1:0] pc_target,
  output logic            pc_load,
  output logic            mc_abort
);
  localparam logic [STW-1:0] COLD = STW'((1 << ST_ERL) | (1 << ST_BEV));

  logic enter;
  assign enter = take_srst | take_nmi;

  always_ff @(posedge clk) begin
    if (rst) begin
      status    <= COLD;
      cerr_ew   <= 1'b0;
      err_pc    <= '0;
      pc_target <= '0;
      pc_load   <= 1'b0;
      mc_abort  <= 1'b0;
    end else begin
      pc_load  <= enter;
      mc_abort <= take_srst;
      if (enter) begin
        status[ST_SR]  <= 1'b1;
        status[ST_ERL] <= 1'b1;
        status[ST_BEV] <= 1'b1;
        status[ST_TS]  <= 1'b0;
        cerr_ew        <= 1'b0;
        err_pc         <= next_pc;
        pc_target      <= VEC;
      end else begin
        if (st_wr_en) status  <= st_wr_data;
        if (ew_set)   cerr_ew <= 1'b1;
      end
    end
  end

  // R3: entry bits and vector
  a_r3_entry_bits: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> (status[ST_SR] && status[ST_ERL] && status[ST_BEV] &&
                 !status[ST_TS] && !cerr_ew));
  a_r3_vector: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> (pc_target == VEC));
  a_r3_err_pc: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> (err_pc == $past(next_pc)));
  // R6: abort only accompanies an entry
  a_r6_abort_with_load: assert property (@(posedge clk) disable iff (rst)
    mc_abort |-> pc_load);
endmodule

// File: rtl/nmi_srst_ctrl.sv
module nmi_srst_ctrl
  import nmi_srst_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int STW  = 8,
  parameter int IRW  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            srst_req_a,
  input  logic            nmi_pin_a,
  input  logic            ireg_wr_en,
  input  logic [IRW-1:0]  ireg_wr_data,
  input  logic            core_running,
  input  logic            insn_boundary,
  input  logic [XLEN-1:0] next_pc,
  input  logic            st_wr_en,
  input  logic [STW-1:0]  st_wr_data,
  input  logic            ew_set,
  output logic [STW-1:0]  status,
  output logic            cerr_ew,
  output logic [XLEN-1:0] err_pc,
  output logic [XLEN-1:0] pc_target,
  output logic            pc_load,
  output logic            mc_abort
);
  logic [1:0] rise;
  logic       srst_take, nmi_take, nmi_pend;

  nmi_srst_sync #(.W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .a   ({nmi_pin_a, srst_req_a}),
    .rise(rise)
  );

  assign srst_take = rise[0];
  assign nmi_take  = !srst_take && nmi_pend && core_running && insn_boundary;

  nmi_pend_latch #(.IRW(IRW), .BIT(IREG_NMI_BIT)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .pin_rise(rise[1]),
    .wr_en   (ireg_wr_en),
    .wr_data (ireg_wr_data),
    .clr     (srst_take | nmi_take),
    .pend    (nmi_pend)
  );

  nmi_arch_state #(.XLEN(XLEN), .STW(STW)) u_state (
    .clk       (clk),
    .rst       (rst),
    .take_srst (srst_take),
    .take_nmi  (nmi_take),
    .next_pc   (next_pc),
    .st_wr_en  (st_wr_en),
    .st_wr_data(st_wr_data),
    .ew_set    (ew_set),
    .status    (status),
    .cerr_ew   (cerr_ew),
    .err_pc    (err_pc),
    .pc_target (pc_target),
    .pc_load   (pc_load),
    .mc_abort  (mc_abort)
  );

  // R5: an NMI entry only follows a running core at a boundary
  a_r5_boundary_only: assert property (@(posedge clk) disable iff (rst)
    (pc_load && !mc_abort) |-> $past(core_running && insn_boundary));
  // R9: a soft reset drops any pending NMI
  a_r9_srst_drops_nmi: assert property (@(posedge clk) disable iff (rst)
    srst_take |=> !nmi_pend);
endmodule

// File: tb/nmi_srst_ctrl_bench.sv
`timescale 1ns/1ps
module nmi_srst_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        srst_req_a, nmi_pin_a, ireg_wr_en;
  logic [7:0]  ireg_wr_data;
  logic        core_running, insn_boundary;
  logic [63:0] next_pc;
  logic        st_wr_en;
  logic [7:0]  st_wr_data;
  logic        ew_set;
  logic [7:0]  status;
  logic        cerr_ew;
  logic [63:0] err_pc, pc_target;
  logic        pc_load, mc_abort;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  localparam logic [63:0] VEC = 64'hFFFF_FFFF_BFC0_0000;

  always #10 clk = ~clk;

  nmi_srst_ctrl u_nmi_srst_ctrl (
    .clk(clk), .rst(rst), .srst_req_a(srst_req_a), .nmi_pin_a(nmi_pin_a),
    .ireg_wr_en(ireg_wr_en), .ireg_wr_data(ireg_wr_data),
    .core_running(core_running), .insn_boundary(insn_boundary),
    .next_pc(next_pc), .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
    .ew_set(ew_set), .status(status), .cerr_ew(cerr_ew), .err_pc(err_pc),
    .pc_target(pc_target), .pc_load(pc_load), .mc_abort(mc_abort)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_loads(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (pc_load) cnt++;
    end
  endtask

  task automatic set_status(input logic [7:0] v, input logic ew);
    st_wr_en = 1'b1; st_wr_data = v; ew_set = ew;
    step(1);
    st_wr_en = 1'b0; ew_set = 1'b0;
  endtask

  task automatic ireg_write(input logic [7:0] d);
    ireg_wr_en = 1'b1; ireg_wr_data = d;
    step(1);
    ireg_wr_en = 1'b0; ireg_wr_data = '0;
  endtask

  task automatic t_reset;
    chk("R1", "status", status, 64'h06);
    chk("R1", "cerr_ew", cerr_ew, 0);
    chk("R1", "err_pc", err_pc, 0);
    chk("R1", "pc_target", pc_target, 0);
    chk("R1", "pc_load/mc_abort", {pc_load, mc_abort}, 0);
  endtask

  task automatic t_srst_idle;
    int cnt;
    core_running = 1'b0; insn_boundary = 1'b0;
    next_pc = 64'h0000_0000_8000_1234;
    set_status(8'hA8, 1'b1);
    chk("R11", "status write", status, 64'hA8);
    chk("R11", "ew set", cerr_ew, 1);
    srst_req_a = 1'b1;
    step(2);
    chk("R2", "no load before third edge", pc_load, 0);
    step(1);
    chk("R2", "load pulse", pc_load, 1);
    chk("R6", "abort on soft reset", mc_abort, 1);
    chk("R3", "status bits", status, 64'hA7);
    chk("R3", "ew cleared", cerr_ew, 0);
    chk("R3", "err_pc", err_pc, 64'h0000_0000_8000_1234);
    chk("R3", "vector", pc_target, VEC);
    step(1);
    chk("R2", "single-cycle load", {pc_load, mc_abort}, 0);
    count_loads(6, cnt);
    chk("R7", "held soft reset re-entries", cnt, 0);
    srst_req_a = 1'b0;
    step(4);
  endtask

  task automatic t_nmi_pin;
    int cnt;
    core_running = 1'b1; insn_boundary = 1'b1;
    next_pc = 64'h0000_0000_8000_2000;
    set_status(8'h58, 1'b1);
    nmi_pin_a = 1'b1;
    step(3);
    chk("R7", "no NMI load before fourth edge", pc_load, 0);
    step(1);
    chk("R7", "NMI load", pc_load, 1);
    chk("R6", "no abort on NMI", mc_abort, 0);
    chk("R3", "NMI status bits", status, 64'h57);
    chk("R3", "NMI err_pc", err_pc, 64'h0000_0000_8000_2000);
    count_loads(6, cnt);
    chk("R7", "held NMI pin re-entries", cnt, 0);
    nmi_pin_a = 1'b0;
    step(4);
  endtask

  task automatic t_nmi_wait;
    int cnt;
    core_running = 1'b1; insn_boundary = 1'b0;
    nmi_pin_a = 1'b1;
    step(3);
    nmi_pin_a = 1'b0;
    count_loads(8, cnt);
    chk("R5", "no entry off boundary", cnt, 0);
    core_running = 1'b0; insn_boundary = 1'b1;
    count_loads(3, cnt);
    chk("R5", "no entry while not running", cnt, 0);
    core_running = 1'b1;
    step(1);
    chk("R5", "entry once at boundary", pc_load, 1);
    step(3);
  endtask

  task automatic t_ireg;
    int cnt;
    core_running = 1'b1; insn_boundary = 1'b1;
    ireg_write(8'hBF);
    count_loads(4, cnt);
    chk("R8", "write without bit 6", cnt, 0);
    ireg_write(8'h40);
    chk("R8", "no load on write edge", pc_load, 0);
    step(1);
    chk("R8", "load after bit-6 write", pc_load, 1);
    count_loads(6, cnt);
    chk("R8", "pending cleared after entry", cnt, 0);
  endtask

  task automatic t_erl;
    set_status(8'h02, 1'b0);
    chk("R10", "ERL preset", status, 64'h02);
    ireg_write(8'h40);
    step(1);
    chk("R10", "NMI taken with ERL set", pc_load, 1);
    chk("R10", "status after", status, 64'h07);
    step(3);
  endtask

  task automatic t_identical;
    logic [7:0]  s_st;
    logic        s_ew;
    logic [63:0] s_epc, s_tgt;
    next_pc = 64'h0000_0000_8000_3ABC;
    core_running = 1'b0; insn_boundary = 1'b0;
    set_status(8'hC8, 1'b1);
    srst_req_a = 1'b1;
    step(3);
    s_st = status; s_ew = cerr_ew; s_epc = err_pc; s_tgt = pc_target;
    srst_req_a = 1'b0;
    step(4);
    set_status(8'hC8, 1'b1);
    core_running = 1'b1; insn_boundary = 1'b1;
    nmi_pin_a = 1'b1;
    step(4);
    chk("R4", "same status", status, s_st);
    chk("R4", "same ew/err_pc/target", {cerr_ew, err_pc ^ pc_target},
        {s_ew, s_epc ^ s_tgt});
    chk("R4", "same err_pc", err_pc, s_epc);
    nmi_pin_a = 1'b0;
    step(4);
  endtask

  task automatic t_srst_wins;
    int cnt;
    core_running = 1'b1; insn_boundary = 1'b0;
    ireg_write(8'h40);
    step(2);
    srst_req_a = 1'b1;
    step(3);
    chk("R9", "soft reset entry", {pc_load, mc_abort}, 2'b11);
    srst_req_a = 1'b0;
    insn_boundary = 1'b1;
    count_loads(8, cnt);
    chk("R9", "pending NMI dropped", cnt, 0);
  endtask

  initial begin
    rst = 1'b1; srst_req_a = 1'b0; nmi_pin_a = 1'b0; ireg_wr_en = 1'b0;
    ireg_wr_data = '0; core_running = 1'b0; insn_boundary = 1'b0;
    next_pc = '0; st_wr_en = 1'b0; st_wr_data = '0; ew_set = 1'b0;
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_srst_idle();
    t_nmi_pin();
    t_nmi_wait();
    t_ireg();
    t_erl();
    t_identical();
    t_srst_wins();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule